// File: doc/BRIEF.md
# Bitmap Compressed Index Lookup

This block turns a 12-bit hash code into an entry of a dense pointer array. Most of the 4096 codes hold nothing. Only the occupied codes take a slot, so the pointer memory needs one entry per occupied code rather than one per code. A 4096-bit occupancy map is kept as 128 words of 32 bits. A base table holds one running count per map word, which is the number of occupied codes in all lower words. For an occupied code, the dense slot is the base of its word plus the number of set bits below the code's bit position in that word. An unoccupied code returns an empty result.

Lookups enter a three-stage pipeline that accepts one request every cycle. The stages are: map and base read, rank and add, pointer read. A single load port fills the map, base and pointer memories word by word. It is used only while no lookup is in flight.

Top module: `bci_lookup`

## Requirements
- R1: While reset is asserted, and on the first sample after it, `out_valid` and `out_hit` are 0.
- R2: Each cycle with `lk_valid` high produces exactly one cycle with `out_valid` high, three clock edges later; no other cycle has `out_valid` high.
- R3: A burst of back-to-back requests, one per cycle, yields the same number of results, with no gaps and none lost.
- R4: If bit `lk_code[4:0]` of map word `lk_code[11:5]` is 0, the result has `out_hit` 0 and `out_ptr` all ones.
- R5: If that bit is 1, `out_hit` is 1 and `out_ptr` is the pointer stored at dense slot base[`lk_code[11:5]`] plus the count of set bits of the word below position `lk_code[4:0]`.
- R6: A code at bit position 0 of an occupied word reads the slot equal to that word's base.
- R7: A code at bit position 31 of a full word reads the slot equal to base plus 31.
- R8: The load port decodes `ld_sel` as 0 = map word, 1 = base entry (low 8 bits of `ld_data`), 2 = pointer (low 20 bits of `ld_data`). Value 3 writes nothing.
- R9: `out_hit` is never 1 while `out_valid` is 0.
- R10: A write becomes visible to a lookup requested in the cycle right after it. `ld_en` is high only while no lookup is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to `clk` |
| lk_valid | input | 1 | Lookup request strobe |
| lk_code | input | 12 | Hash code to look up |
| ld_en | input | 1 | Table write strobe |
| ld_sel | input | 2 | Target memory: 0 map, 1 base, 2 pointer, 3 none |
| ld_addr | input | 8 | Word address within the chosen memory |
| ld_data | input | 32 | Write data |
| out_valid | output | 1 | Result valid, three cycles after the request |
| out_hit | output | 1 | Code is occupied |
| out_ptr | output | 20 | Pointer on a hit, all ones on a miss |

## Verification
The hardest case to reach is a code whose rank depends on many set bits below it, in a word whose base is far from zero. With a sparse random map, most hits land in words that hold one or two bits. The bench therefore forces a completely full last word, reads its bit 31, and biases half of the random codes onto occupied positions found by scanning the model map. A live change of a map word that keeps the bit count, together with a pointer rewrite followed at once by a lookup, covers visibility of writes one cycle after they occur.

// File: rtl/bci_pkg.sv
package bci_pkg;
  typedef enum logic [1:0] {
    LD_MAP  = 2'd0,
    LD_BASE = 2'd1,
    LD_PTR  = 2'd2,
    LD_NONE = 2'd3
  } ld_target_e;
endpackage

// File: rtl/bci_occ_store.sv
module bci_occ_store #(
  parameter int WORD_W = 32,
  parameter int WORDS  = 128,
  parameter int WA_W   = 7,
  parameter int IDX_W  = 8,
  parameter int LD_AW  = 8
) (
  input  logic              clk,
  input  logic              wr_map,
  input  logic              wr_base,
  input  logic [LD_AW-1:0]  wr_addr,
  input  logic [WORD_W-1:0] map_data,
  input  logic [IDX_W-1:0]  base_data,
  input  logic              rd_en,
  input  logic [WA_W-1:0]   rd_addr,
  output logic [WORD_W-1:0] word_q,
  output logic [IDX_W-1:0]  base_q
);
  logic [WORD_W-1:0] map_mem  [WORDS];
  logic [IDX_W-1:0]  base_mem [WORDS];
  logic              addr_ok;

  assign addr_ok = 32'(wr_addr) < WORDS;

  always_ff @(posedge clk) begin
    if (wr_map && addr_ok) map_mem[wr_addr[WA_W-1:0]] <= map_data;
    if (wr_base && addr_ok) base_mem[wr_addr[WA_W-1:0]] <= base_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) begin
      word_q <= map_mem[rd_addr];
      base_q <= base_mem[rd_addr];
    end
  end
endmodule

// File: rtl/bci_rank.sv
module bci_rank #(
  parameter int WORD_W = 32,
  parameter int BIT_W  = 5
) (
  input  logic [WORD_W-1:0] word,
  input  logic [BIT_W-1:0]  bit_idx,
  output logic              occupied,
  output logic [BIT_W:0]    below_cnt
);
  logic [WORD_W-1:0] below;

  generate
    for (genvar i = 0; i < WORD_W; i++) begin : g_mask
      assign below[i] = word[i] & (BIT_W'(i) < bit_idx);
    end
  endgenerate

  always_comb begin
    below_cnt = '0;
    for (int k = 0; k < WORD_W; k++) begin
      below_cnt = below_cnt + (BIT_W+1)'(below[k]);
    end
  end

  assign occupied = word[bit_idx];
endmodule

// File: rtl/bci_ptr_store.sv
module bci_ptr_store #(
  parameter int PTR_DEPTH = 256,
  parameter int PTR_W     = 20,
  parameter int IDX_W     = 8,
  parameter int LD_AW     = 8
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [LD_AW-1:0] wr_addr,
  input  logic [PTR_W-1:0] wr_data,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_addr,
  output logic [PTR_W-1:0] ptr_q
);
  logic [PTR_W-1:0] ptr_mem [PTR_DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en && (32'(wr_addr) < PTR_DEPTH)) ptr_mem[wr_addr[IDX_W-1:0]] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) ptr_q <= ptr_mem[rd_addr];
  end
endmodule

// File: rtl/bci_lookup.sv
module bci_lookup #(
  parameter int CODE_W    = 12,
  parameter int WORD_W    = 32,
  parameter int PTR_DEPTH = 256,
  parameter int PTR_W     = 20,
  localparam int BIT_W    = $clog2(WORD_W),
  localparam int WA_W     = CODE_W - BIT_W,
  localparam int WORDS    = 2 ** WA_W,
  localparam int IDX_W    = $clog2(PTR_DEPTH),
  localparam int LD_AW    = (WA_W > IDX_W) ? WA_W : IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [CODE_W-1:0] lk_code,
  input  logic              ld_en,
  input  logic [1:0]        ld_sel,
  input  logic [LD_AW-1:0]  ld_addr,
  input  logic [WORD_W-1:0] ld_data,
  output logic              out_valid,
  output logic              out_hit,
  output logic [PTR_W-1:0]  out_ptr
);
  import bci_pkg::*;

  // load decode
  logic wr_map, wr_base, wr_ptr;
  assign wr_map  = ld_en && (ld_sel == LD_MAP);
  assign wr_base = ld_en && (ld_sel == LD_BASE);
  assign wr_ptr  = ld_en && (ld_sel == LD_PTR);

  // stage 1: map word and base read
  logic              s1_valid_d, s1_valid_q;
  logic [BIT_W-1:0]  s1_bit_q;
  logic [WORD_W-1:0] s1_word;
  logic [IDX_W-1:0]  s1_base;

  bci_occ_store #(
    .WORD_W(WORD_W), .WORDS(WORDS), .WA_W(WA_W), .IDX_W(IDX_W), .LD_AW(LD_AW)
  ) u_occ (
    .clk      (clk),
    .wr_map   (wr_map),
    .wr_base  (wr_base),
    .wr_addr  (ld_addr),
    .map_data (ld_data),
    .base_data(ld_data[IDX_W-1:0]),
    .rd_en    (lk_valid),
    .rd_addr  (lk_code[CODE_W-1:BIT_W]),
    .word_q   (s1_word),
    .base_q   (s1_base)
  );

  // stage 2: rank and add
  logic             rk_occ;
  logic [BIT_W:0]   rk_cnt;
  logic             s2_valid_d, s2_valid_q;
  logic             s2_hit_d, s2_hit_q;
  logic [IDX_W-1:0] s2_idx_d, s2_idx_q;

  bci_rank #(.WORD_W(WORD_W), .BIT_W(BIT_W)) u_rank (
    .word     (s1_word),
    .bit_idx  (s1_bit_q),
    .occupied (rk_occ),
    .below_cnt(rk_cnt)
  );

  // stage 3: pointer read
  logic             s3_valid_d, s3_valid_q;
  logic             s3_hit_d, s3_hit_q;
  logic [PTR_W-1:0] s3_ptr;

  bci_ptr_store #(
    .PTR_DEPTH(PTR_DEPTH), .PTR_W(PTR_W), .IDX_W(IDX_W), .LD_AW(LD_AW)
  ) u_ptr (
    .clk    (clk),
    .wr_en  (wr_ptr),
    .wr_addr(ld_addr),
    .wr_data(ld_data[PTR_W-1:0]),
    .rd_en  (s2_valid_q),
    .rd_addr(s2_idx_q),
    .ptr_q  (s3_ptr)
  );

  // next-state logic
  always_comb begin
    s1_valid_d = lk_valid;
    s2_valid_d = s1_valid_q;
    s2_hit_d   = rk_occ;
    s2_idx_d   = s1_base + IDX_W'(rk_cnt);
    s3_valid_d = s2_valid_q;
    s3_hit_d   = s2_valid_q && s2_hit_q;
  end

  // control registers with reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid_q <= 1'b0;
      s2_valid_q <= 1'b0;
      s3_valid_q <= 1'b0;
      s3_hit_q   <= 1'b0;
    end else begin
      s1_valid_q <= s1_valid_d;
      s2_valid_q <= s2_valid_d;
      s3_valid_q <= s3_valid_d;
      s3_hit_q   <= s3_hit_d;
    end
  end

  // datapath registers, enabled by the stage valid
  always_ff @(posedge clk) begin
    if (lk_valid) s1_bit_q <= lk_code[BIT_W-1:0];
    if (s1_valid_q) begin
      s2_hit_q <= s2_hit_d;
      s2_idx_q <= s2_idx_d;
    end
  end

  assign out_valid = s3_valid_q;
  assign out_hit   = s3_hit_q;
  assign out_ptr   = s3_hit_q ? s3_ptr : '1;
endmodule

// File: rtl/bci_lookup_chk.sv
module bci_lookup_chk #(
  parameter int PTR_W = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lk_valid,
  input logic             ld_en,
  input logic             out_valid,
  input logic             out_hit,
  input logic [PTR_W-1:0] out_ptr
);
  logic [2:0] req_hist;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_hist <= '0;
    else        req_hist <= {req_hist[1:0], lk_valid};
  end

  always @(posedge clk) begin
    if (!rst_n) AST_RESET_QUIET: assert (!out_valid && !out_hit); // R1
  end

  AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == req_hist[2]); // R2

  AST_MISS_IS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_hit) |-> (out_ptr == '1)); // R4

  AST_HIT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_hit |-> out_valid); // R9

  AST_NO_LOAD_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |-> (!lk_valid && (req_hist == 3'b000))); // R10
endmodule

bind bci_lookup bci_lookup_chk #(.PTR_W(PTR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .ld_en(ld_en),
  .out_valid(out_valid), .out_hit(out_hit), .out_ptr(out_ptr)
);

// File: tb/bci_lookup_test.sv
module bci_lookup_test;
  localparam int PTR_W = 20;

  logic        clk;
  logic        rst_n;
  logic        lk_valid;
  logic [11:0] lk_code;
  logic        ld_en;
  logic [1:0]  ld_sel;
  logic [7:0]  ld_addr;
  logic [31:0] ld_data;
  logic        out_valid;
  logic        out_hit;
  logic [PTR_W-1:0] out_ptr;

  bci_lookup uut (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_code(lk_code),
    .ld_en(ld_en), .ld_sel(ld_sel), .ld_addr(ld_addr), .ld_data(ld_data),
    .out_valid(out_valid), .out_hit(out_hit), .out_ptr(out_ptr)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;
  int vcount = 0;

  logic [31:0]      bm [128];
  logic [7:0]       bb [128];
  logic [PTR_W-1:0] pm [256];

  // expectation pipe
  logic             p_v   [3];
  logic             p_h   [3];
  logic [PTR_W-1:0] p_p   [3];
  string            p_tag [3];

  function automatic logic exp_hit(input logic [11:0] c);
    return bm[c[11:5]][c[4:0]];
  endfunction

  function automatic int exp_slot(input logic [11:0] c);
    int n = 0;
    for (int k = 0; k < 32; k++) if (k < int'(c[4:0]) && bm[c[11:5]][k]) n++;
    return int'(bb[c[11:5]]) + n;
  endfunction

  function automatic logic [PTR_W-1:0] exp_ptr(input logic [11:0] c);
    if (!exp_hit(c)) return '1;
    return pm[exp_slot(c)];
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [11:0] c, input string tag);
    string t;
    @(negedge clk);
    check(out_valid === p_v[2], "R2", "out_valid", longint'(out_valid), longint'(p_v[2]));
    if (out_valid === 1'b1) vcount++;
    if (p_v[2]) begin
      check(out_hit === p_h[2], p_tag[2], "out_hit", longint'(out_hit), longint'(p_h[2]));
      check(out_ptr === p_p[2], p_tag[2], "out_ptr", longint'(out_ptr), longint'(p_p[2]));
    end else begin
      check(out_hit === 1'b0, "R9", "out_hit idle", longint'(out_hit), 0);
    end
    for (int s = 2; s > 0; s--) begin
      p_v[s] = p_v[s-1]; p_h[s] = p_h[s-1]; p_p[s] = p_p[s-1]; p_tag[s] = p_tag[s-1];
    end
    t = tag;
    if (t == "") t = exp_hit(c) ? "R5" : "R4";
    p_v[0] = v; p_h[0] = v && exp_hit(c); p_p[0] = exp_ptr(c); p_tag[0] = t;
    ld_en = 1'b0;
    lk_valid = v;
    lk_code = c;
  endtask

  task automatic load(input logic [1:0] sel, input int addr, input logic [31:0] data);
    @(negedge clk);
    lk_valid = 1'b0;
    ld_en = 1'b1;
    ld_sel = sel;
    ld_addr = 8'(addr);
    ld_data = data;
  endtask

  function automatic logic [11:0] pick_code();
    logic [6:0] w = 7'($urandom);
    logic [4:0] b = 5'($urandom);
    if ($urandom % 2 == 0 && bm[w] != 0) begin
      while (!bm[w][b]) b = b + 5'd1;
    end
    return {w, b};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R2 watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int total;
    void'($urandom(32'd2024));
    rst_n = 1'b1; lk_valid = 0; lk_code = 0; ld_en = 0; ld_sel = 0; ld_addr = 0; ld_data = 0;
    for (int s = 0; s < 3; s++) begin p_v[s] = 0; p_h[s] = 0; p_p[s] = '1; p_tag[s] = "R2"; end
    #1 rst_n = 1'b0;

    // model tables
    for (int w = 0; w < 128; w++) bm[w] = '0;
    bm[5] = 32'h0000_0001; bm[9] = 32'h8000_0101; bm[127] = 32'hFFFF_FFFF;
    total = 36;
    for (int w = 0; w < 127; w++) begin
      if (w != 5 && w != 9) begin
        logic [31:0] r = $urandom & $urandom & $urandom & $urandom & $urandom;
        if (total + $countones(r) <= 256) begin bm[w] = r; total += $countones(r); end
      end
    end
    total = 0;
    for (int w = 0; w < 128; w++) begin bb[w] = 8'(total); total += $countones(bm[w]); end
    for (int i = 0; i < 256; i++) pm[i] = PTR_W'($urandom) & {{(PTR_W-1){1'b1}}, 1'b0};

    repeat (4) @(posedge clk);
    @(negedge clk);
    check(out_valid === 1'b0 && out_hit === 1'b0, "R1", "reset outputs",
          longint'({out_valid, out_hit}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid === 1'b0, "R1", "after release", longint'(out_valid), 0);

    for (int w = 0; w < 128; w++) load(2'd0, w, bm[w]);
    for (int w = 0; w < 128; w++) load(2'd1, w, {24'd0, bb[w]});
    for (int i = 0; i < 256; i++) load(2'd2, i, {12'd0, pm[i]});
    load(2'd3, 5, 32'hFFFF_FFFF);   // R8: sel 3 must not touch map word 5

    step(1, {7'd5, 5'd3}, "R8");
    step(1, {7'd5, 5'd0}, "R5");
    step(1, {7'd9, 5'd0}, "R6");
    step(1, {7'd127, 5'd31}, "R7");
    step(1, {7'd127, 5'd0}, "R6");
    step(1, {7'd9, 5'd31}, "R5");
    step(1, {7'd6, 5'd0}, "");
    repeat (3) step(0, 12'd0, "");

    // R3 burst
    vcount = 0;
    for (int i = 0; i < 20; i++) step(1, pick_code(), "");
    repeat (3) step(0, 12'd0, "");
    check(vcount == 20, "R3", "burst results", vcount, 20);

    for (int i = 0; i < 3000; i++) step(($urandom % 4) != 0, pick_code(), "");
    repeat (3) step(0, 12'd0, "");

    // R10: same-count map change and pointer rewrite, looked up at once
    bm[5] = 32'h0000_0008;
    pm[exp_slot({7'd5, 5'd3})] = 20'h5A5A4;
    load(2'd0, 5, bm[5]);
    load(2'd2, exp_slot({7'd5, 5'd3}), {12'd0, 20'h5A5A4});
    step(1, {7'd5, 5'd3}, "R10");
    step(1, {7'd5, 5'd0}, "R10");
    repeat (3) step(0, 12'd0, "");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule